// File: doc/BRIEF.md
# Cycle-Based Timer Interrupt Unit

This unit raises interrupt flags for a time-triggered communication controller. It watches the 6-bit communication cycle counter and the macrotick counter that a protocol engine supplies. It has two timers. Each timer is programmed with a cycle set and a macrotick offset. The cycle set is a base value together with a power-of-two repetition. A timer flag fires when the current cycle belongs to the timer's cycle set and the macrotick count reaches the offset. The unit also flags the start of every cycle. It raises a further flag when the offset-correction measurement count at the end of an odd cycle falls below a programmed minimum.

All flags are sticky and live in one status register. The host clears a flag by writing a one to its bit. An enable register selects which flags drive the single level interrupt line. That line is registered, so it follows the masked status one clock later. The host reaches the unit through a plain register port: the write is synchronous and the read is combinational.

Top module: `cyc_timer_irq`

## Requirements
- R1: While reset is asserted, the status register reads 0, the enable register and all timer configuration registers read 0, and `irq_o` is 0.
- R2: With cycle and macrotick inputs held at 0, the first clock after reset sets both timer flags. Status then reads 0x00C0 and `irq_o` stays 0, because enable is 0.
- R3: Timer n sets its flag when both of these hold:
  - `(cycle_i & (2^k - 1)) == base`, where base is bits 5:0 of its cycle-set register and k (0 to 6) is bits 10:8 of that register;
  - `mtick_i` equals its offset register.
  Timer 0 sets status bit 6 and timer 1 sets status bit 7.
- R4: A timer flag sets only on the clock where its match condition becomes true. If it is cleared while the macrotick value still equals the offset, it stays clear.
- R5: Status bit 5 (cycle start) sets on any clock where `cycle_i` differs from its value on the previous clock.
- R6: Status bit 4 (missing offset correction) sets on a cycle change when the previous cycle was odd and `meas_i` is below the minimum in register 6, bits 3:0. It does not set when the previous cycle was even or when `meas_i` is at or above the minimum.
- R7: A write to register 0 clears each status bit written as 1. It leaves bits written as 0 unchanged. Flags otherwise hold their value.
- R8: When a hardware set and a host clear hit the same status bit on the same clock, the bit ends up set.
- R9: `irq_o` equals the OR over all bits of (status AND enable) as it was on the previous clock.
- R10: Only bits 7:4 of the status and enable registers exist; all other bits read as 0.
- R11: Register addresses are:
  - 0: status
  - 1: enable
  - 2: timer 0 cycle set
  - 3: timer 0 offset
  - 4: timer 1 cycle set
  - 5: timer 1 offset
  - 6: minimum measurement count

  Configuration registers read back as written in their defined fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_i | input | 6 | Current communication cycle number |
| mtick_i | input | MT_W | Current macrotick count |
| meas_i | input | MEAS_W | Offset-correction measurement count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Combinational register read data |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
Flag sets from the cycle and macrotick inputs and host writes all take effect on the first clock edge after they are applied. Status therefore reads back changed one clock after the stimulus. `irq_o` carries one more register, so it is due one clock after the status change. The bench drives stimulus on falling edges and reads status at the falling edge right after the effective rising edge. It checks `irq_o` both at that point, where it must still show the old value, and one clock later. Checks of the edge-only matching behaviour (R4) and of the clear behaviour (R7) hold the inputs for extra clocks and confirm that nothing reappears.

// File: rtl/cti_pkg.sv
package cti_pkg;
  localparam int CYC_W    = 6;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int CODE_W   = 3;
  localparam int N_TIMERS = 2;

  localparam int BIT_T1  = 7;
  localparam int BIT_T0  = 6;
  localparam int BIT_CYC = 5;
  localparam int BIT_OC  = 4;
  localparam logic [REG_W-1:0] FLAG_MASK = 16'h00F0;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_T0_SET = 3'd2;
  localparam logic [ADDR_W-1:0] A_T0_OFF = 3'd3;
  localparam logic [ADDR_W-1:0] A_T1_SET = 3'd4;
  localparam logic [ADDR_W-1:0] A_T1_OFF = 3'd5;
  localparam logic [ADDR_W-1:0] A_OC_MIN = 3'd6;

  // Low-bit mask for a repetition of 2^code; codes beyond the counter width saturate.
  function automatic logic [CYC_W-1:0] rep_mask(input logic [CODE_W-1:0] code);
    logic [CYC_W-1:0] m;
    for (int i = 0; i < CYC_W; i++) m[i] = (i < int'(code));
    return m;
  endfunction

  function automatic logic in_cycle_set(input logic [CYC_W-1:0] cyc,
                                        input logic [CYC_W-1:0] base,
                                        input logic [CODE_W-1:0] code);
    return (cyc & rep_mask(code)) == base;
  endfunction
endpackage

// File: rtl/cti_timer_match.sv
module cti_timer_match
  import cti_pkg::*;
#(
  parameter int MT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic [MT_W-1:0]   mtick_i,
  input  logic [CYC_W-1:0]  base_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [MT_W-1:0]   offset_i,
  output logic              hit_o
);
  logic eq, eq_q;

  assign eq = in_cycle_set(cycle_i, base_i, code_i) && (mtick_i == offset_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  assign hit_o = eq && !eq_q;
endmodule

// File: rtl/cti_cycle_events.sv
module cti_cycle_events
  import cti_pkg::*;
#(
  parameter int MEAS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic [MEAS_W-1:0] meas_i,
  input  logic [MEAS_W-1:0] min_i,
  output logic              cyc_new_o,
  output logic              oc_miss_o
);
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cycle_i;
  end

  assign cyc_new_o = (cycle_i != cyc_q);
  assign oc_miss_o = cyc_new_o && cyc_q[0] && (meas_i < min_i);
endmodule

// File: rtl/cti_flag_reg.sv
module cti_flag_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/cyc_timer_irq.sv
module cyc_timer_irq
  import cti_pkg::*;
#(
  parameter int MT_W   = 14,
  parameter int MEAS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cycle_i,
  input  logic [MT_W-1:0]   mtick_i,
  input  logic [MEAS_W-1:0] meas_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [15:0]       rd_data_o,
  output logic              irq_o
);
  logic [CYC_W-1:0]  base_q [N_TIMERS];
  logic [CODE_W-1:0] code_q [N_TIMERS];
  logic [MT_W-1:0]   off_q  [N_TIMERS];
  logic [MEAS_W-1:0] min_q;
  logic [REG_W-1:0]  en_q;
  logic [REG_W-1:0]  status_q;
  logic [REG_W-1:0]  set_vec, clr_vec;
  logic [N_TIMERS-1:0] t_hit;
  logic cyc_new, oc_miss;
  logic irq_q;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      min_q <= '0;
      for (int i = 0; i < N_TIMERS; i++) begin
        base_q[i] <= '0;
        code_q[i] <= '0;
        off_q[i]  <= '0;
      end
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_ENABLE: en_q <= wr_data_i & FLAG_MASK;
        A_T0_SET: begin base_q[0] <= wr_data_i[5:0]; code_q[0] <= wr_data_i[10:8]; end
        A_T0_OFF: off_q[0] <= wr_data_i[MT_W-1:0];
        A_T1_SET: begin base_q[1] <= wr_data_i[5:0]; code_q[1] <= wr_data_i[10:8]; end
        A_T1_OFF: off_q[1] <= wr_data_i[MT_W-1:0];
        A_OC_MIN: min_q <= wr_data_i[MEAS_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
    cti_timer_match #(.MT_W(MT_W)) match_i (
      .clk(clk), .rst_n(rst_n), .cycle_i(cycle_i), .mtick_i(mtick_i),
      .base_i(base_q[g]), .code_i(code_q[g]), .offset_i(off_q[g]),
      .hit_o(t_hit[g])
    );
  end

  cti_cycle_events #(.MEAS_W(MEAS_W)) events_i (
    .clk(clk), .rst_n(rst_n), .cycle_i(cycle_i), .meas_i(meas_i),
    .min_i(min_q), .cyc_new_o(cyc_new), .oc_miss_o(oc_miss)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_T0]  = t_hit[0];
    set_vec[BIT_T1]  = t_hit[1];
    set_vec[BIT_CYC] = cyc_new;
    set_vec[BIT_OC]  = oc_miss;
  end

  assign clr_vec = (wr_en_i && wr_addr_i == A_STATUS) ? wr_data_i : '0;

  cti_flag_reg #(.W(REG_W)) flags_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .status_o(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_q & en_q);
  end
  assign irq_o = irq_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_STATUS: rd_data_o = status_q;
      A_ENABLE: rd_data_o = en_q;
      A_T0_SET: begin rd_data_o[5:0] = base_q[0]; rd_data_o[10:8] = code_q[0]; end
      A_T0_OFF: rd_data_o[MT_W-1:0] = off_q[0];
      A_T1_SET: begin rd_data_o[5:0] = base_q[1]; rd_data_o[10:8] = code_q[1]; end
      A_T1_OFF: rd_data_o[MT_W-1:0] = off_q[1];
      A_OC_MIN: rd_data_o[MEAS_W-1:0] = min_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/cyc_timer_irq_chk.sv
module cyc_timer_irq_chk #(
  parameter int MT_W = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] status_q,
  input logic [15:0] en_q,
  input logic [15:0] set_vec,
  input logic [15:0] clr_vec,
  input logic [1:0]  t_hit,
  input logic [MT_W-1:0] mtick_i,
  input logic [MT_W-1:0] off0,
  input logic [MT_W-1:0] off1,
  input logic        irq_o
);
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(status_q & en_q)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_vec)) & ~status_q) == 16'h0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~status_q) == 16'h0));

  assert_spare_bits_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | en_q) & 16'hFF0F) == 16'h0);

  assert_t0_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    t_hit[0] |-> mtick_i == off0);

  assert_t1_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    t_hit[1] |-> mtick_i == off1);

  assert_t0_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    t_hit[0] |=> !t_hit[0]);

  assert_t1_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    t_hit[1] |=> !t_hit[1]);
endmodule

bind cyc_timer_irq cyc_timer_irq_chk #(.MT_W(MT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .status_q(status_q), .en_q(en_q),
  .set_vec(set_vec), .clr_vec(clr_vec), .t_hit(t_hit), .mtick_i(mtick_i),
  .off0(off_q[0]), .off1(off_q[1]), .irq_o(irq_o)
);

// File: tb/cyc_timer_irq_tb_top.sv
module cyc_timer_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MT_W = 14;
  localparam int MEAS_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cycle = '0;
  logic [MT_W-1:0] mtick = '0;
  logic [MEAS_W-1:0] meas = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_timer_irq #(.MT_W(MT_W), .MEAS_W(MEAS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cycle_i(cycle), .mtick_i(mtick), .meas_i(meas),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk_reg("R1 status", 3'd0, 16'h0000);
    chk_reg("R1 enable", 3'd1, 16'h0000);
    chk_reg("R1 t0 set", 3'd2, 16'h0000);
    chk_reg("R1 t1 off", 3'd5, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rst_n = 1'b1;
    tick();
    chk_reg("R2 status", 3'd0, 16'h00C0);
    chk("R2 irq", {15'd0, irq}, 16'h0000);
    tick();
    chk("R2 irq later", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_enable_irq();
    wr(3'd1, 16'hFFFF);
    chk_reg("R10 enable bits", 3'd1, 16'h00F0);
    chk("R9 irq not yet", {15'd0, irq}, 16'h0000);
    tick();
    chk("R9 irq raised", {15'd0, irq}, 16'h0001);
  endtask

  task automatic t_clear();
    wr(3'd0, 16'h0000);
    chk_reg("R7 write zero keeps", 3'd0, 16'h00C0);
    wr(3'd0, 16'h0040);
    chk_reg("R7 clear bit6", 3'd0, 16'h0080);
    wr(3'd0, 16'h0080);
    chk_reg("R7 clear bit7", 3'd0, 16'h0000);
    chk("R9 irq lags", {15'd0, irq}, 16'h0001);
    tick();
    chk("R9 irq dropped", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_config();
    wr(3'd3, 16'd10);
    wr(3'd2, 16'h0201);
    wr(3'd5, 16'd20);
    wr(3'd4, 16'h0303);
    chk_reg("R11 t0 set", 3'd2, 16'h0201);
    chk_reg("R11 t0 off", 3'd3, 16'd10);
    chk_reg("R11 t1 set", 3'd4, 16'h0303);
    chk_reg("R11 t1 off", 3'd5, 16'd20);
    chk_reg("R11 status untouched", 3'd0, 16'h0000);
  endtask

  task automatic t_timer0();
    cycle = 6'd5; tick();
    wr(3'd0, 16'hFFFF);
    mtick = 14'd10; tick();
    chk_reg("R3 t0 match", 3'd0, 16'h0040);
    wr(3'd0, 16'hFFFF);
    tick(); tick();
    chk_reg("R4 no refire while held", 3'd0, 16'h0000);
    mtick = '0;
    cycle = 6'd6; tick();
    wr(3'd0, 16'hFFFF);
    mtick = 14'd10; tick();
    chk_reg("R3 t0 cycle outside set", 3'd0, 16'h0000);
    mtick = '0;
  endtask

  task automatic t_timer1();
    cycle = 6'd11; tick();
    wr(3'd0, 16'hFFFF);
    mtick = 14'd20; tick();
    chk_reg("R3 t1 match", 3'd0, 16'h0080);
    mtick = '0;
    wr(3'd0, 16'hFFFF);
  endtask

  task automatic t_rep64();
    wr(3'd2, 16'h0621);
    cycle = 6'd33; tick();
    wr(3'd0, 16'hFFFF);
    mtick = 14'd10; tick();
    chk_reg("R3 rep64 match", 3'd0, 16'h0040);
    mtick = '0;
    cycle = 6'd1; tick();
    wr(3'd0, 16'hFFFF);
    mtick = 14'd10; tick();
    chk_reg("R3 rep64 no match", 3'd0, 16'h0000);
    mtick = '0;
  endtask

  task automatic t_cycle_start();
    cycle = 6'd2; tick();
    chk_reg("R5 cycle start", 3'd0, 16'h0020);
    wr(3'd0, 16'hFFFF);
    tick();
    chk_reg("R5 held cycle no flag", 3'd0, 16'h0000);
  endtask

  task automatic t_offset_corr();
    wr(3'd6, 16'd4);
    chk_reg("R11 min readback", 3'd6, 16'd4);
    meas = 4'd2;
    cycle = 6'd7; tick();
    wr(3'd0, 16'hFFFF);
    cycle = 6'd8; tick();
    chk_reg("R6 odd end short", 3'd0, 16'h0030);
    wr(3'd0, 16'hFFFF);
    cycle = 6'd9; tick();
    chk_reg("R6 even end no flag", 3'd0, 16'h0020);
    wr(3'd0, 16'hFFFF);
    meas = 4'd5;
    cycle = 6'd10; tick();
    chk_reg("R6 enough measurements", 3'd0, 16'h0020);
    wr(3'd0, 16'hFFFF);
  endtask

  task automatic t_set_wins();
    cycle = 6'd12;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0020;
    tick();
    wr_en = 1'b0;
    chk_reg("R8 set beats clear", 3'd0, 16'h0020);
    tick();
    chk("R9 irq from cycle flag", {15'd0, irq}, 16'h0001);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_enable_irq();
    t_clear();
    t_config();
    t_timer0();
    t_timer1();
    t_rep64();
    t_cycle_start();
    t_offset_corr();
    t_set_wins();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule